// File: doc/BRIEF.md
# Decoded-Bit Output Packer

This block takes a finished decoding result (up to `MAX_K` hard-decision bits, a runtime length K and a one-bit CRC verdict) and sends it downstream as a packet of 64-bit beats. The result is loaded in a single cycle through a valid/idle handshake. The block then emits ceil(K/64) beats, starting with the lowest-numbered bits. It marks the first and last beats and packs the leftover bits of a non-multiple-of-64 length into the low lanes of the final beat.

The downstream side uses ready with a one-cycle latency. A beat may appear only in a cycle whose preceding cycle had `src_ready` high. When the downstream withholds ready, the packer waits on the current beat. The verdict flag is presented alongside the beats and does not move while a packet is in flight.

The packer reports `load_idle` to its producer. `load_idle` also rises in the cycle of the final beat, so the next result can be handed over without a dead cycle between packets.

Top module: `opk_out_packer`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous) and after it, until a load, `src_valid`, `src_sop`, `src_eop` and `src_pass` are 0 and `load_idle` is 1. `src_data` is all zeros in every cycle without a beat.
- R2: A load is taken only on a clock edge where `load_valid` and `load_idle` are both high. A `load_valid` pulse while `load_idle` is low changes neither the bits, the length nor the flag of the packet in flight, and starts no extra packet.
- R3: `load_len` is the bit count K as an unsigned binary number in 1..`MAX_K`. The packet has exactly ceil(K/64) beats, and beat i carries result bits [64i+63:64i] on `src_data[63:0]`.
- R4: When K is not a multiple of 64, the final beat carries the top K mod 64 result bits in `src_data[(K mod 64)-1:0]`, and all lanes above them are 0. For K < 64 this is the only beat.
- R5: `src_valid` is high in a cycle exactly when a packet is pending and `src_ready` was high in the previous cycle. A cycle without a beat keeps the beat position, so no beat is skipped or repeated.
- R6: `src_sop` is high on the first beat only and `src_eop` on the last beat only. Both are high together on a single-beat packet. After the last beat, no further beat follows unless a new result was loaded.
- R7: `src_pass` equals the loaded verdict (1 = CRC passed, 0 = failed or CRC off) on every beat of the packet and does not change from the start beat to the end beat. It is 0 while no result is pending.
- R8: `load_idle` is low from the load until the end beat. It is high in the cycle of the end beat, so a result loaded in that cycle is sent as the next packet, which can begin in the very next cycle.
- R9: No beat appears before a result is loaded. The first beat appears no earlier than the cycle after the load, and exactly then if `src_ready` was high in the load cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Producer offers a finished result |
| load_bits | input | MAX_K | Decoded bits, bit 0 first on the bus |
| load_len | input | LEN_W | Bit count K (1..MAX_K) |
| load_pass | input | 1 | CRC verdict of the result |
| load_idle | output | 1 | Packer can take a result this cycle |
| src_ready | input | 1 | Downstream ready, one-cycle latency |
| src_valid | output | 1 | Beat present on `src_data` |
| src_sop | output | 1 | First beat of the packet |
| src_eop | output | 1 | Last beat of the packet |
| src_data | output | 64 | Beat payload |
| src_pass | output | 1 | CRC verdict, held for the packet |

## Verification
The end beat of one packet and the load of the next can land in the same cycle. `load_idle` is high during the end beat, and the producer hands over a fresh result on that edge. The bench provokes this by driving a new load in the very cycle it sees `src_eop`, with ready held high. It then judges the outcome by requiring a start beat of the new result in the following cycle, carrying the new length, data and verdict. The old packet must have produced no extra beat, and the new one must have lost none.

// File: rtl/opk_pkg.sv
`timescale 1ns/1ps
package opk_pkg;
  localparam int unsigned OPK_LANES    = 64;
  localparam int unsigned OPK_LANE_SH  = 6;

  typedef enum logic {
    OPK_IDLE = 1'b0,
    OPK_SEND = 1'b1
  } opk_state_e;
endpackage

// File: rtl/opk_result_store.sv
`timescale 1ns/1ps
module opk_result_store #(
  parameter int unsigned MAX_K = 1024,
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [MAX_K-1:0] cap_bits,
  input  logic [LEN_W-1:0] cap_len,
  input  logic             cap_pass,
  output logic [MAX_K-1:0] bits_q,
  output logic [LEN_W-1:0] len_q,
  output logic             pass_q
);
  logic [MAX_K-1:0] bits_n;
  logic [LEN_W-1:0] len_n;
  logic             pass_n;

  always_comb begin
    bits_n = bits_q;
    len_n  = len_q;
    pass_n = pass_q;
    if (cap_en) begin
      bits_n = cap_bits;
      len_n  = cap_len;
      pass_n = cap_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      len_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      bits_q <= bits_n;
      len_q  <= len_n;
      pass_q <= pass_n;
    end
  end
endmodule

// File: rtl/opk_beat_ctrl.sv
`timescale 1ns/1ps
module opk_beat_ctrl
  import opk_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_acc,
  input  logic [LEN_W-1:0] len,
  input  logic             src_ready,
  output logic [IDX_W-1:0] beat_idx,
  output logic             fire,
  output logic             first,
  output logic             last,
  output logic             idle,
  output logic             active
);
  opk_state_e       state_q, state_n;
  logic [IDX_W-1:0] idx_n;
  logic             rdy_q, rdy_n;
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W-1:0] last_idx;
  logic [LEN_W-1:0] idx_ext;

  always_comb begin
    len_m1   = len - LEN_W'(1);
    last_idx = len_m1 >> OPK_LANE_SH;
    idx_ext  = LEN_W'(beat_idx);
    active   = (state_q == OPK_SEND);
    fire     = active && rdy_q;
    first    = fire && (beat_idx == '0);
    last     = fire && (idx_ext == last_idx);
    idle     = !active || last;
  end

  always_comb begin
    rdy_n   = src_ready;
    state_n = state_q;
    idx_n   = beat_idx;
    if (load_acc) begin
      state_n = OPK_SEND;
      idx_n   = '0;
    end else if (last) begin
      state_n = OPK_IDLE;
      idx_n   = '0;
    end else if (fire) begin
      idx_n   = beat_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= OPK_IDLE;
      beat_idx <= '0;
      rdy_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      beat_idx <= idx_n;
      rdy_q    <= rdy_n;
    end
  end

  AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(src_ready)); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire) |=> $stable(beat_idx)); // R5

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> (active && beat_idx == '0)); // R9
endmodule

// File: rtl/opk_lane_sel.sv
`timescale 1ns/1ps
module opk_lane_sel
  import opk_pkg::*;
#(
  parameter int unsigned MAX_K = 1024,
  parameter int unsigned LEN_W = 11,
  parameter int unsigned IDX_W = 4
) (
  input  logic [MAX_K-1:0]     bits,
  input  logic [LEN_W-1:0]     len,
  input  logic [IDX_W-1:0]     beat_idx,
  input  logic                 fire,
  output logic [OPK_LANES-1:0] data
);
  localparam int unsigned BEATS = MAX_K / OPK_LANES;
  localparam int unsigned SLOTS = 1 << IDX_W;

  logic [OPK_LANES-1:0] words [SLOTS];
  logic [OPK_LANES-1:0] keep;
  logic [LEN_W:0]       base;
  logic [LEN_W:0]       rem;

  for (genvar b = 0; b < SLOTS; b++) begin : g_word
    if (b < BEATS) begin : g_real
      assign words[b] = bits[b*OPK_LANES +: OPK_LANES];
    end else begin : g_pad
      assign words[b] = '0;
    end
  end

  always_comb begin
    base = (LEN_W+1)'(beat_idx) << OPK_LANE_SH;
    rem  = {1'b0, len} - base;
  end

  for (genvar l = 0; l < OPK_LANES; l++) begin : g_keep
    assign keep[l] = (rem > (LEN_W+1)'(l));
  end

  always_comb begin
    data = '0;
    if (fire) data = words[beat_idx] & keep;
  end
endmodule

// File: rtl/opk_out_packer.sv
`timescale 1ns/1ps
module opk_out_packer
  import opk_pkg::*;
#(
  parameter int unsigned MAX_K = 1024,
  parameter int unsigned LEN_W = $clog2(MAX_K + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [MAX_K-1:0] load_bits,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_pass,
  output logic             load_idle,
  input  logic             src_ready,
  output logic             src_valid,
  output logic             src_sop,
  output logic             src_eop,
  output logic [63:0]      src_data,
  output logic             src_pass
);
  localparam int unsigned BEATS = MAX_K / OPK_LANES;
  localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [MAX_K-1:0] bits_q;
  logic [LEN_W-1:0] len_q;
  logic             pass_q;
  logic             load_acc;
  logic [IDX_W-1:0] beat_idx;
  logic             fire, first, last, idle, active;

  assign load_acc = load_valid && idle;

  opk_result_store #(.MAX_K(MAX_K), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(load_acc),
    .cap_bits(load_bits), .cap_len(load_len), .cap_pass(load_pass),
    .bits_q(bits_q), .len_q(len_q), .pass_q(pass_q)
  );

  opk_beat_ctrl #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_acc(load_acc), .len(len_q),
    .src_ready(src_ready), .beat_idx(beat_idx), .fire(fire),
    .first(first), .last(last), .idle(idle), .active(active)
  );

  opk_lane_sel #(.MAX_K(MAX_K), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_lanes (
    .bits(bits_q), .len(len_q), .beat_idx(beat_idx), .fire(fire),
    .data(src_data)
  );

  assign load_idle = idle;
  assign src_valid = fire;
  assign src_sop   = first;
  assign src_eop   = last;
  assign src_pass  = pass_q && active;

  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !load_idle) |=> ($stable(len_q) && $stable(pass_q))); // R2

  AST_PASS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_eop) |=> $stable(src_pass)); // R7

  AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_eop && !load_valid) |=> !src_valid); // R6

  AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_eop) |-> load_idle); // R8
endmodule

// File: tb/tb_opk_out_packer.sv
`timescale 1ns/1ps
module tb_opk_out_packer;
  localparam int MAX_K = 1024;
  localparam int LEN_W = 11;

  typedef struct packed {
    logic [10:0] k;
    logic        pass;
    logic [31:0] seed;
    logic [15:0] rpat;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{11'd1,    1'b1, 32'h1234_5678, 16'hFFFF},
    '{11'd63,   1'b0, 32'h0BAD_F00D, 16'hAAAA},
    '{11'd64,   1'b1, 32'h5EED_0001, 16'h0F0F},
    '{11'd65,   1'b1, 32'hC0FF_EE11, 16'hFFFF},
    '{11'd100,  1'b0, 32'h7777_1234, 16'hF3E1},
    '{11'd128,  1'b1, 32'h2468_ACE0, 16'h8421},
    '{11'd600,  1'b1, 32'h1357_9BDF, 16'hFFFF},
    '{11'd1000, 1'b0, 32'hDEAD_BEEF, 16'hCCCC},
    '{11'd1024, 1'b1, 32'hFACE_0042, 16'h7777},
    '{11'd12,   1'b1, 32'h0000_0099, 16'h0001}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load_valid;
  logic [MAX_K-1:0] load_bits;
  logic [LEN_W-1:0] load_len;
  logic             load_pass;
  logic             load_idle;
  logic             src_ready;
  logic             src_valid, src_sop, src_eop, src_pass;
  logic [63:0]      src_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  opk_out_packer #(.MAX_K(MAX_K), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_bits(load_bits),
    .load_len(load_len), .load_pass(load_pass), .load_idle(load_idle),
    .src_ready(src_ready), .src_valid(src_valid), .src_sop(src_sop),
    .src_eop(src_eop), .src_data(src_data), .src_pass(src_pass)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [MAX_K-1:0] gen_bits(input logic [31:0] seed);
    logic [MAX_K-1:0] r;
    logic [31:0] x;
    x = seed | 32'h1;
    for (int w = 0; w < MAX_K/32; w++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      r[w*32 +: 32] = x;
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_beat(input logic [MAX_K-1:0] b,
                                            input int k, input int i);
    logic [63:0] w;
    int n;
    w = b[i*64 +: 64];
    n = k - i*64;
    if (n < 64) w = w & ((64'h1 << n) - 64'h1);
    return w;
  endfunction

  task automatic load_pkt(input int k, input logic pass,
                          input logic [MAX_K-1:0] b, input logic r0);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!load_idle && guard < 2000);
    chk(load_idle, "R8", "idle before load", 64'(load_idle), 64'd1);
    load_valid = 1'b1;
    load_bits  = b;
    load_len   = LEN_W'(k);
    load_pass  = pass;
    src_ready  = r0;
  endtask

  task automatic drain(input int k, input logic pass, input logic [MAX_K-1:0] b,
                       input logic [15:0] rpat, input bit inject, input bit chain,
                       input int ck, input logic cpass, input logic [MAX_K-1:0] cb);
    int idx = 0;
    int c = 1;
    int nb = (k + 63) / 64;
    bit done = 0;
    for (int it = 0; it < 1200 && !done; it++) begin
      @(negedge clk);
      chk(src_valid === src_ready, "R5", "valid vs previous ready",
          64'(src_valid), 64'(src_ready));
      if (it == 0)
        chk(src_valid === src_ready, "R9", "first beat timing",
            64'(src_valid), 64'(src_ready));
      if (src_valid === 1'b1) begin
        chk(src_data === exp_beat(b, k, idx),
            (idx == nb-1 && (k % 64) != 0) ? "R4" : "R3", "beat data",
            src_data, exp_beat(b, k, idx));
        chk(src_sop === (idx == 0), "R6", "sop", 64'(src_sop), 64'(idx == 0));
        chk(src_eop === (idx == nb-1), "R6", "eop", 64'(src_eop), 64'(idx == nb-1));
        chk(src_pass === pass, "R7", "pass flag", 64'(src_pass), 64'(pass));
        chk(load_idle === (idx == nb-1), "R8", "idle during beat",
            64'(load_idle), 64'(idx == nb-1));
        if (idx == nb-1) done = 1;
        idx++;
      end else begin
        chk(load_idle === 1'b0, "R8", "idle while pending", 64'(load_idle), 64'd0);
        chk(src_data === 64'd0, "R1", "data without beat", src_data, 64'd0);
      end
      load_valid = 1'b0;
      if (inject && it == 2 && !done) begin
        load_valid = 1'b1;
        load_bits  = ~b;
        load_len   = LEN_W'(5);
        load_pass  = ~pass;
      end
      if (done && chain) begin
        load_valid = 1'b1;
        load_bits  = cb;
        load_len   = LEN_W'(ck);
        load_pass  = cpass;
      end
      src_ready = rpat[c % 16];
      c++;
    end
    if (!done) chk(1'b0, "R3", "packet incomplete", 64'(idx), 64'(nb));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [MAX_K-1:0] b1, b2;
    rst_n = 1'b0;
    load_valid = 1'b0;
    load_bits = '0;
    load_len = '0;
    load_pass = 1'b0;
    src_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(src_valid === 1'b0 && src_sop === 1'b0 && src_eop === 1'b0, "R1",
        "flags in reset", {61'd0, src_valid, src_sop, src_eop}, 64'd0);
    chk(load_idle === 1'b1, "R1", "idle in reset", 64'(load_idle), 64'd1);
    chk(src_pass === 1'b0, "R1", "pass in reset", 64'(src_pass), 64'd0);
    chk(src_data === 64'd0, "R1", "data in reset", src_data, 64'd0);
    rst_n = 1'b1;
    // R9: no beat before any load, even with ready high
    repeat (3) begin
      @(negedge clk);
      chk(src_valid === 1'b0, "R9", "beat before load", 64'(src_valid), 64'd0);
      chk(src_pass === 1'b0, "R7", "pass with nothing pending", 64'(src_pass), 64'd0);
    end

    // Table of vectors
    foreach (VECS[v]) begin
      b1 = gen_bits(VECS[v].seed);
      load_pkt(int'(VECS[v].k), VECS[v].pass, b1, VECS[v].rpat[0]);
      drain(int'(VECS[v].k), VECS[v].pass, b1, VECS[v].rpat, 0, 0, 0, 1'b0, '0);
    end

    // R2: load while busy is ignored
    b1 = gen_bits(32'hA5A5_0F0F);
    load_pkt(300, 1'b1, b1, 1'b1);
    drain(300, 1'b1, b1, 16'hFFFF, 1, 0, 0, 1'b0, '0);
    @(negedge clk);
    chk(src_valid === 1'b0 && load_idle === 1'b1, "R2", "no packet from ignored load",
        {62'd0, src_valid, load_idle}, 64'd1);
    load_valid = 1'b0;

    // R8: load in the end-beat cycle, next packet starts right after
    b1 = gen_bits(32'h0102_0304);
    b2 = gen_bits(32'h5566_7788);
    load_pkt(70, 1'b1, b1, 1'b1);
    drain(70, 1'b1, b1, 16'hFFFF, 0, 1, 40, 1'b0, b2);
    drain(40, 1'b0, b2, 16'hFFFF, 0, 0, 0, 1'b0, '0);
    @(negedge clk);
    chk(src_valid === 1'b0, "R6", "no beat after end", 64'(src_valid), 64'd0);

    // R1: asynchronous reset in the middle of a packet
    b1 = gen_bits(32'h9999_1111);
    load_pkt(512, 1'b1, b1, 1'b1);
    @(negedge clk);
    load_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(src_valid === 1'b0 && load_idle === 1'b1 && src_pass === 1'b0, "R1",
        "state after mid-packet reset", {61'd0, src_valid, load_idle, src_pass},
        64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(src_valid === 1'b0, "R9", "no beat after reset release", 64'(src_valid), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule